// File: doc/BRIEF.md
# Conditional Execution Evaluator

This block decides whether a conditional instruction is allowed to execute. A 4-bit condition field from the instruction is evaluated against the processor's status flags: ALU zero, negative, overflow and carry, multiplier overflow, shifter overflow and ALU x-input sign, plus a loop-counter-expired signal. The result is a single condition-true bit. Two of the sixteen codes do not test a fixed flag. Instead they test a source chosen by software through a 4-bit select register. That source can be one of fourteen general-purpose pins or one of two status flags.

The pins arrive from outside the clock domain, so each one passes through a two-flop synchronizer before it is used. The select register is written through a simple enable/data port. A written value governs evaluation from the cycle after the capturing clock edge.

Apart from those two registered paths, the output is combinational from the condition field and the flag inputs. Those inputs are expected to come from registers elsewhere in the core. There is no streaming data here, so the block has no valid/ready handshake and no back-pressure: every pin is a plain level.

Top module: `cond_eval`

## Requirements
- R1: Code 0000 is true exactly when the zero flag is 1. Code 0001 is true exactly when the zero flag is 0.
- R2: Let less = negative XOR overflow. The signed compare codes are:
  - Code 0100 gives less.
  - Code 0101 gives NOT less.
  - Code 0011 gives less OR zero.
  - Code 0010 gives NOT (less OR zero).
- R3: Codes 0110 and 0111 give overflow and its inverse. Codes 1000 and 1001 give carry and its inverse.
- R4: Codes 1100 and 1101 give multiplier overflow and its inverse. Code 1110 is true when the counter-expired input is 0. Code 1111 is always true.
- R5: Code 1010 gives the selected software source and code 1011 gives its inverse. The source is chosen by the select register value:
  - Values 0–7 choose synchronized pins 0–7 (true when high).
  - Value 8 chooses the x-sign flag.
  - Value 9 chooses the shifter overflow flag.
  - Values 10–15 choose synchronized pins 8–13.
- R6: A write (`sw_wr_en` high at a rising edge) loads `sw_wr_data` into the select register. Before that edge, evaluation uses the old value. From that edge on, it uses the new value. A cycle without a write keeps the value.
- R7: A change on a pin reaches `cond_true` only after the second rising edge following the change. After the first edge the old pin level is still in use.
- R8: While `rst_n` is low at a rising edge, the select register and all synchronizer stages clear to 0. Right after reset, code 1011 is therefore true even if pin 0 is high.
- R9: With the clock quiet, a change of `cond_code` or of any flag input changes `cond_true` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_code | input | 4 | Condition field of the instruction |
| flag_zero | input | 1 | ALU result zero |
| flag_neg | input | 1 | ALU result negative |
| flag_ovf | input | 1 | ALU overflow |
| flag_carry | input | 1 | ALU carry |
| flag_mac_ovf | input | 1 | Multiplier overflow |
| flag_shf_ovf | input | 1 | Shifter overflow |
| flag_xsign | input | 1 | ALU x-input sign |
| cnt_expired | input | 1 | Loop counter expired |
| pins | input | 14 | Asynchronous general-purpose pin levels |
| sw_wr_en | input | 1 | Write strobe for the software select register |
| sw_wr_data | input | 4 | Value written to the software select register |
| cond_true | output | 1 | Condition evaluates true |

## Verification
The flag-driven codes have no register on their path. The bench changes `cond_code` and the flags at a falling edge and samples `cond_true` 1 ns later, in the same cycle.

A select-register write is driven at a falling edge. The old selection is checked before the next rising edge and the new one at the falling edge after it.

Pin levels are checked twice: the old level at the falling edge after one rising edge, and the new level only after two rising edges. No sample is ever taken at a rising edge.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_EQ      = 4'b0000,
    CC_NE      = 4'b0001,
    CC_GT      = 4'b0010,
    CC_LE      = 4'b0011,
    CC_LT      = 4'b0100,
    CC_GE      = 4'b0101,
    CC_OVF     = 4'b0110,
    CC_NOVF    = 4'b0111,
    CC_CARRY   = 4'b1000,
    CC_NCARRY  = 4'b1001,
    CC_SW      = 4'b1010,
    CC_NSW     = 4'b1011,
    CC_MOVF    = 4'b1100,
    CC_NMOVF   = 4'b1101,
    CC_CNT_RUN = 4'b1110,
    CC_ALWAYS  = 4'b1111
  } cond_code_e;

  typedef struct packed {
    logic cnt_expired;
    logic xsign;
    logic shf_ovf;
    logic mac_ovf;
    logic carry;
    logic ovf;
    logic neg;
    logic zero;
  } status_flags_t;

  // Select values that route a status flag instead of a pin.
  localparam logic [3:0] SEL_XSIGN   = 4'd8;
  localparam logic [3:0] SEL_SHF_OVF = 4'd9;

endpackage

// File: rtl/cond_pin_sync.sv
module cond_pin_sync #(
  parameter int WIDTH  = 14,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cond_sw_reg.sv
module cond_sw_reg #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_data;
  end

endmodule

// File: rtl/cond_sw_select.sv
module cond_sw_select
  import cond_eval_pkg::*;
#(
  parameter int PIN_W = 14,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [PIN_W-1:0] pins_sync,
  input  logic             xsign,
  input  logic             shf_ovf,
  output logic             src_bit
);

  localparam int LOW_PINS  = int'(SEL_XSIGN);
  localparam int FLAG_GAP  = 2;

  // Select code that addresses pin i: the two flag codes sit between
  // the lower and upper pin groups.
  function automatic logic [SEL_W-1:0] code_of_pin(input int i);
    if (i < LOW_PINS) code_of_pin = SEL_W'(i);
    else              code_of_pin = SEL_W'(i + FLAG_GAP);
  endfunction

  logic pin_hit;

  always_comb begin
    pin_hit = 1'b0;
    for (int i = 0; i < PIN_W; i++) begin
      if (code_of_pin(i) == sel) pin_hit = pins_sync[i];
    end
  end

  always_comb begin
    if (sel == SEL_W'(SEL_XSIGN))        src_bit = xsign;
    else if (sel == SEL_W'(SEL_SHF_OVF)) src_bit = shf_ovf;
    else                                 src_bit = pin_hit;
  end

endmodule

// File: rtl/cond_code_eval.sv
module cond_code_eval
  import cond_eval_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  status_flags_t     flags,
  input  logic              sw_bit,
  output logic              cond_true
);

  logic less;
  logic less_eq;

  assign less    = flags.neg ^ flags.ovf;
  assign less_eq = less | flags.zero;

  always_comb begin
    unique case (cond_code_e'(code))
      CC_EQ:      cond_true = flags.zero;
      CC_NE:      cond_true = ~flags.zero;
      CC_GT:      cond_true = ~less_eq;
      CC_LE:      cond_true = less_eq;
      CC_LT:      cond_true = less;
      CC_GE:      cond_true = ~less;
      CC_OVF:     cond_true = flags.ovf;
      CC_NOVF:    cond_true = ~flags.ovf;
      CC_CARRY:   cond_true = flags.carry;
      CC_NCARRY:  cond_true = ~flags.carry;
      CC_SW:      cond_true = sw_bit;
      CC_NSW:     cond_true = ~sw_bit;
      CC_MOVF:    cond_true = flags.mac_ovf;
      CC_NMOVF:   cond_true = ~flags.mac_ovf;
      CC_CNT_RUN: cond_true = ~flags.cnt_expired;
      CC_ALWAYS:  cond_true = 1'b1;
      default:    cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int PIN_W       = 14,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cond_code,
  input  logic              flag_zero,
  input  logic              flag_neg,
  input  logic              flag_ovf,
  input  logic              flag_carry,
  input  logic              flag_mac_ovf,
  input  logic              flag_shf_ovf,
  input  logic              flag_xsign,
  input  logic              cnt_expired,
  input  logic [PIN_W-1:0]  pins,
  input  logic              sw_wr_en,
  input  logic [SEL_W-1:0]  sw_wr_data,
  output logic              cond_true
);

  status_flags_t    flags;
  logic [PIN_W-1:0] pins_sync;
  logic [SEL_W-1:0] sw_sel_q;
  logic             sw_bit;

  assign flags = '{cnt_expired: cnt_expired,
                   xsign:       flag_xsign,
                   shf_ovf:     flag_shf_ovf,
                   mac_ovf:     flag_mac_ovf,
                   carry:       flag_carry,
                   ovf:         flag_ovf,
                   neg:         flag_neg,
                   zero:        flag_zero};

  cond_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pins),
    .sync_out (pins_sync)
  );

  cond_sw_reg #(
    .SEL_W (SEL_W)
  ) u_swreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sw_wr_en),
    .wr_data (sw_wr_data),
    .sel_q   (sw_sel_q)
  );

  cond_sw_select #(
    .PIN_W (PIN_W),
    .SEL_W (SEL_W)
  ) u_swsel (
    .sel       (sw_sel_q),
    .pins_sync (pins_sync),
    .xsign     (flag_xsign),
    .shf_ovf   (flag_shf_ovf),
    .src_bit   (sw_bit)
  );

  cond_code_eval u_eval (
    .code      (cond_code),
    .flags     (flags),
    .sw_bit    (sw_bit),
    .cond_true (cond_true)
  );

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int PIN_W = 14,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cond_code,
  input logic             flag_zero,
  input logic             flag_neg,
  input logic             flag_ovf,
  input logic             flag_xsign,
  input logic [PIN_W-1:0] pins,
  input logic             sw_wr_en,
  input logic [SEL_W-1:0] sw_wr_data,
  input logic [SEL_W-1:0] sw_sel,
  input logic [PIN_W-1:0] pins_sync,
  input logic             cond_true
);

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b0000 |-> cond_true == flag_zero);

  p_less_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b0100 |-> cond_true == (flag_neg ^ flag_ovf));

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b1111 |-> cond_true);

  p_xsign_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'b1010 && sw_sel == 4'd8) |-> cond_true == flag_xsign);

  p_wr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> sw_sel == $past(sw_wr_data));

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> $stable(sw_sel));

  p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    age_q == 2'd3 |-> pins_sync == $past(pins, 2));

endmodule

bind cond_eval cond_eval_chk #(.PIN_W(PIN_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cond_code  (cond_code),
  .flag_zero  (flag_zero),
  .flag_neg   (flag_neg),
  .flag_ovf   (flag_ovf),
  .flag_xsign (flag_xsign),
  .pins       (pins),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_data (sw_wr_data),
  .sw_sel     (sw_sel_q),
  .pins_sync  (pins_sync),
  .cond_true  (cond_true)
);

// File: tb/tb_cond_eval.sv
`timescale 1ns/1ps
module tb_cond_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cond_code = '0;
  logic [7:0]  fl = '0; // {cnt,xsign,shf,mac,carry,ovf,neg,zero}
  logic [13:0] pins = '0;
  logic        sw_wr_en = 1'b0;
  logic [3:0]  sw_wr_data = '0;
  logic        cond_true;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  cond_eval dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cond_code    (cond_code),
    .flag_zero    (fl[0]),
    .flag_neg     (fl[1]),
    .flag_ovf     (fl[2]),
    .flag_carry   (fl[3]),
    .flag_mac_ovf (fl[4]),
    .flag_shf_ovf (fl[5]),
    .flag_xsign   (fl[6]),
    .cnt_expired  (fl[7]),
    .pins         (pins),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .cond_true    (cond_true)
  );

  // Expected value for the flag-driven codes, from the requirements.
  function automatic logic ref_flag(input logic [3:0] c, input logic [7:0] f);
    logic lt;
    lt = f[1] ^ f[2];
    case (c)
      4'h0: ref_flag = f[0];
      4'h1: ref_flag = !f[0];
      4'h2: ref_flag = !(lt || f[0]);
      4'h3: ref_flag = lt || f[0];
      4'h4: ref_flag = lt;
      4'h5: ref_flag = !lt;
      4'h6: ref_flag = f[2];
      4'h7: ref_flag = !f[2];
      4'h8: ref_flag = f[3];
      4'h9: ref_flag = !f[3];
      4'hC: ref_flag = f[4];
      4'hD: ref_flag = !f[4];
      4'hE: ref_flag = !f[7];
      default: ref_flag = 1'b1;
    endcase
  endfunction

  // Expected software source for a select value.
  function automatic logic ref_src(input logic [3:0] s, input logic [13:0] p,
                                   input logic [7:0] f);
    if (s < 4'd8)       ref_src = p[s];
    else if (s == 4'd8) ref_src = f[6];
    else if (s == 4'd9) ref_src = f[5];
    else                ref_src = p[s - 4'd2];
  endfunction

  task automatic check(input logic got, input logic exp, input string req,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic write_sel(input logic [3:0] v);
    @(negedge clk);
    sw_wr_en   = 1'b1;
    sw_wr_data = v;
    @(negedge clk);
    sw_wr_en   = 1'b0;
  endtask

  // Apply pins and wait two rising edges so the synchronizer has them.
  task automatic settle_pins(input logic [13:0] p);
    @(negedge clk);
    pins = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset clears select register and synchronizer.
    pins = '1;
    sw_wr_en = 1'b1;
    sw_wr_data = 4'd5;
    repeat (4) @(negedge clk);
    sw_wr_en = 1'b0;
    rst_n = 1'b1;
    cond_code = 4'hB;
    #1 check(cond_true, 1'b1, "R8", "code 1011 right after reset");
    cond_code = 4'hA;
    #1 check(cond_true, 1'b0, "R8", "code 1010 right after reset");

    // R1..R4, R9: exhaustive flag sweep, sampled 1 ns after the change.
    for (int c = 0; c < 16; c++) begin
      if (c == 10 || c == 11) continue;
      for (int f = 0; f < 256; f++) begin
        @(negedge clk);
        cond_code = 4'(c);
        fl = 8'(f);
        #1;
        if (c < 2)       check(cond_true, ref_flag(4'(c), 8'(f)), "R1", $sformatf("code %0d flags %h", c, f));
        else if (c < 6)  check(cond_true, ref_flag(4'(c), 8'(f)), "R2", $sformatf("code %0d flags %h", c, f));
        else if (c < 10) check(cond_true, ref_flag(4'(c), 8'(f)), "R3", $sformatf("code %0d flags %h", c, f));
        else             check(cond_true, ref_flag(4'(c), 8'(f)), "R4", $sformatf("code %0d flags %h", c, f));
      end
    end

    // R9: combinational response with the clock quiet (mid high phase).
    @(posedge clk);
    #2;
    cond_code = 4'h0; fl = 8'h01;
    #1 check(cond_true, 1'b1, "R9", "zero set");
    fl = 8'h00;
    #1 check(cond_true, 1'b0, "R9", "zero cleared");
    cond_code = 4'h1;
    #1 check(cond_true, 1'b1, "R9", "code switched");

    // R5: every select value, source high and low, other sources opposite.
    for (int s = 0; s < 16; s++) begin
      write_sel(4'(s));
      for (int lvl = 0; lvl < 2; lvl++) begin
        logic [13:0] p;
        logic [7:0]  f;
        if (s < 8 || s > 9) begin
          p = '0;
          if (s < 8) p[s] = 1'b1; else p[s-2] = 1'b1;
          if (lvl == 0) p = ~p;
          f = (lvl == 0) ? 8'h60 : 8'h00;
        end else begin
          p = (lvl == 0) ? '1 : '0;
          f = (s == 8) ? ((lvl == 1) ? 8'h40 : 8'h20)
                       : ((lvl == 1) ? 8'h20 : 8'h40);
        end
        settle_pins(p);
        fl = f;
        cond_code = 4'hA;
        #1 check(cond_true, ref_src(4'(s), p, f), "R5", $sformatf("sel %0d level %0d code 1010", s, lvl));
        check(cond_true, 1'(lvl), "R5", $sformatf("sel %0d level %0d expected level", s, lvl));
        cond_code = 4'hB;
        #1 check(cond_true, !ref_src(4'(s), p, f), "R5", $sformatf("sel %0d level %0d code 1011", s, lvl));
      end
    end

    // R6: write latency. Select pin 2 (low) vs pin 3 (high).
    write_sel(4'd2);
    settle_pins(14'h0008);
    fl = '0;
    cond_code = 4'hA;
    @(negedge clk);
    sw_wr_en = 1'b1;
    sw_wr_data = 4'd3;
    #1 check(cond_true, 1'b0, "R6", "old select before capturing edge");
    @(negedge clk);
    sw_wr_en = 1'b0;
    sw_wr_data = 4'd2;
    #1 check(cond_true, 1'b1, "R6", "new select after capturing edge");
    @(negedge clk);
    #1 check(cond_true, 1'b1, "R6", "select held without write");

    // R7: pin 3 falls; old level after one edge, new after two.
    @(negedge clk);
    pins = 14'h0000;
    #1 check(cond_true, 1'b1, "R7", "same cycle as pin change");
    @(negedge clk);
    #1 check(cond_true, 1'b1, "R7", "after one rising edge");
    @(negedge clk);
    #1 check(cond_true, 1'b0, "R7", "after two rising edges");

    // R8: reset again clears the select register mid-run.
    write_sel(4'd9);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fl = 8'h20; // shifter overflow high, x-sign low
    pins = 14'h0000;
    cond_code = 4'hA;
    #1 check(cond_true, 1'b0, "R8", "select back to pin 0 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule